// File: doc/BRIEF.md
# Inbound Write Ordering Controller

This block sits between the inbound posted-write queues and a coherent interconnect. It decides, cycle by cycle, whether the write at the head of the queue may issue now. It also produces the command type used to issue that write. Each request carries a virtual-channel number, a relaxed-ordering flag, a snoop flag, a full-line flag and a tag. A single counter tracks the writes that have been issued and are not yet globally observed. The counter rises on every accepted write and falls on every observation pulse from the interconnect.

A write that must be ordered is held with `req_ready` low until the counter reads zero. Which writes must be ordered depends on three configuration inputs:

- `cfg_vc1_mode` selects the ordering policy for channel 1.
- `cfg_vc0_strict` forces strict ordering on channel 0.
- `cfg_no_alloc` steers every write onto non-allocating command types.

Top module: `wr_order_ctrl`

## Requirements
- R1: When the outstanding count equals its maximum (2^CNT_W - 1), `req_ready` is low for every request. One observation pulse releases the stall.
- R2: The outstanding count rises by one on each accepted write (`req_valid` and `req_ready` both high). It falls by one on each `obs_pulse` while it is nonzero. A pulse while the count is zero is ignored. A pulse in the same cycle as an accepted write leaves the count unchanged.
- R3: For channel 1 with `cfg_vc1_mode` 2'b01 (serialize) or 2'b00 (reserved, same as serialize), a write is accepted only while the count is zero.
- R4: For channel 1 with `cfg_vc1_mode` 2'b10, writes are accepted while the count is nonzero, except a write whose tag equals FENCE_TAG (default 8'h21). That write waits for a zero count.
- R5: For channel 1 with `cfg_vc1_mode` 2'b11, a non-snooped write with RO=1 is accepted at any count below maximum. A write with RO=0 waits for a zero count.
- R6: For channel 0, a set `cfg_vc0_strict` makes every write wait for a zero count. When it is clear, a non-snooped write with RO=1 does not wait.
- R7: `cfg_vc0_strict` has no effect on channels 2 and above. For those channels, a non-snooped RO=1 write does not wait and any other write waits for a zero count.
- R8: A snooped write is treated as RO=0 wherever the RO bit would relax ordering (channel 0, channels 2 and above, and channel-1 mode 2'b11). It therefore waits for a zero count.
- R9: `issue_cmd` = {allocating, snooped, full_line}. Bit 2 is 1 only for a snooped write while `cfg_no_alloc` is 0. Bit 1 copies `req_snoop` and bit 0 copies `req_full_line`. The codes are: 3'b000/001 non-snooped partial/full, 3'b010/011 snooped non-allocating partial/full, 3'b110/111 snooped allocating partial/full.
- R10: After reset the outstanding count is zero, and any request sees `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vc1_mode | input | 2 | Channel-1 ordering policy |
| cfg_vc0_strict | input | 1 | Treat all channel-0 writes as RO=0 |
| cfg_no_alloc | input | 1 | Use non-allocating command types only |
| req_valid | input | 1 | Head write request present |
| req_ready | output | 1 | Head write may issue this cycle |
| req_vc | input | VC_W | Virtual-channel number |
| req_ro | input | 1 | Relaxed-ordering flag |
| req_snoop | input | 1 | Write is snooped |
| req_full_line | input | 1 | Write covers a full line |
| req_tag | input | TAG_W | Request tag |
| issue_cmd | output | 3 | Command type for the head write |
| obs_pulse | input | 1 | One earlier write reached global observability |

## Verification
The bench builds the block with CNT_W=2, so the counter saturates at 3. Saturation and its release are then reached after three accepted writes, rather than fifteen with the default width. All other parameters keep their defaults, which exercises the default fence tag 8'h21 against the neighbouring tag 8'h20. Every ordering case is reached by preloading 0 to 3 outstanding writes through channel 2, a path that needs no ordering. A sticky counter underflow would also surface within this range.

// File: rtl/wr_order_ctrl.sv
module wr_order_ctrl #(
  parameter int VC_W = 2,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  parameter logic [TAG_W-1:0] FENCE_TAG = TAG_W'('h21)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_vc1_mode,
  input  logic             cfg_vc0_strict,
  input  logic             cfg_no_alloc,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VC_W-1:0]  req_vc,
  input  logic             req_ro,
  input  logic             req_snoop,
  input  logic             req_full_line,
  input  logic [TAG_W-1:0] req_tag,
  output logic [2:0]       issue_cmd,
  input  logic             obs_pulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [1:0] MODE_FENCE = 2'b10;
  localparam logic [1:0] MODE_RO    = 2'b11;

  logic [CNT_W-1:0] cnt_q;
  logic relaxed, need_drain, drained, full, fire, retire;

  assign relaxed = req_ro & ~req_snoop;
  assign drained = (cnt_q == '0);
  assign full    = (cnt_q == CNT_MAX);

  always_comb begin
    if (req_vc == VC_W'(0))
      need_drain = cfg_vc0_strict | ~relaxed;
    else if (req_vc == VC_W'(1))
      case (cfg_vc1_mode)
        MODE_FENCE: need_drain = (req_tag == FENCE_TAG);
        MODE_RO:    need_drain = ~relaxed;
        default:    need_drain = 1'b1;
      endcase
    else
      need_drain = ~relaxed;
  end

  assign req_ready = ~full & (drained | ~need_drain);
  assign fire      = req_valid & req_ready;
  assign retire    = obs_pulse & ~drained;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt_q <= '0;
    else if (fire != retire)
      cnt_q <= fire ? cnt_q + 1'b1 : cnt_q - 1'b1;

  assign issue_cmd = {~cfg_no_alloc & req_snoop, req_snoop, req_full_line};

endmodule

module wr_order_chk #(
  parameter int VC_W = 2,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  parameter logic [TAG_W-1:0] FENCE_TAG = TAG_W'('h21)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_vc1_mode,
  input logic             cfg_vc0_strict,
  input logic             cfg_no_alloc,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VC_W-1:0]  req_vc,
  input logic             req_snoop,
  input logic [TAG_W-1:0] req_tag,
  input logic [2:0]       issue_cmd,
  input logic             obs_pulse,
  input logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_full_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_MAX |-> !req_ready);

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !obs_pulse) |=> cnt_q != '0);

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && obs_pulse && !(req_valid && req_ready)) |=> cnt_q == '0);

  assert_serialize_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vc == VC_W'(1) && !cfg_vc1_mode[1] && cnt_q != '0) |-> !req_ready);

  assert_fence_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vc == VC_W'(1) && cfg_vc1_mode == 2'b10 && req_tag == FENCE_TAG && cnt_q != '0)
      |-> !req_ready);

  assert_vc0_strict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vc == VC_W'(0) && cfg_vc0_strict && cnt_q != '0) |-> !req_ready);

  assert_snoop_ordered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_snoop && cnt_q != '0 && !(req_vc == VC_W'(1) && cfg_vc1_mode != 2'b11))
      |-> !req_ready);

  assert_no_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_no_alloc || !req_snoop) |-> !issue_cmd[2]);

  assert_empty_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '0 |-> req_ready);

endmodule

bind wr_order_ctrl wr_order_chk #(
  .VC_W(VC_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .FENCE_TAG(FENCE_TAG)
) u_wr_order_chk (
  .clk(clk), .rst_n(rst_n), .cfg_vc1_mode(cfg_vc1_mode),
  .cfg_vc0_strict(cfg_vc0_strict), .cfg_no_alloc(cfg_no_alloc),
  .req_valid(req_valid), .req_ready(req_ready), .req_vc(req_vc),
  .req_snoop(req_snoop), .req_tag(req_tag), .issue_cmd(issue_cmd),
  .obs_pulse(obs_pulse), .cnt_q(cnt_q)
);

// File: tb/test_wr_order_ctrl.sv
module test_wr_order_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_vc1_mode = 2'b01;
  logic cfg_vc0_strict = 1'b1, cfg_no_alloc = 1'b0;
  logic req_valid = 1'b0, req_ro = 1'b0, req_snoop = 1'b0, req_full_line = 1'b0;
  logic [1:0] req_vc = '0;
  logic [7:0] req_tag = '0;
  logic obs_pulse = 1'b0;
  logic req_ready;
  logic [2:0] issue_cmd;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wr_order_ctrl #(.CNT_W(2)) i_wr_order_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_vc1_mode(cfg_vc1_mode),
    .cfg_vc0_strict(cfg_vc0_strict), .cfg_no_alloc(cfg_no_alloc),
    .req_valid(req_valid), .req_ready(req_ready), .req_vc(req_vc),
    .req_ro(req_ro), .req_snoop(req_snoop), .req_full_line(req_full_line),
    .req_tag(req_tag), .issue_cmd(issue_cmd), .obs_pulse(obs_pulse)
  );

  // pre, vc, mode, strict, noalloc, ro, snoop, full, tag, exp_ready, exp_cmd
  localparam int NV = 17;
  localparam logic [22:0] VEC [NV] = '{
    {2'd1, 2'd1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 3'b001},
    {2'd0, 2'd1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 3'b110},
    {2'd1, 2'd1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 3'b000},
    {2'd2, 2'd1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h20, 1'b1, 3'b111},
    {2'd2, 2'd1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h21, 1'b0, 3'b001},
    {2'd0, 2'd1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h21, 1'b1, 3'b000},
    {2'd1, 2'd1, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 3'b001},
    {2'd1, 2'd1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'b001},
    {2'd1, 2'd1, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 3'b011},
    {2'd1, 2'd0, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 3'b000},
    {2'd1, 2'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 3'b000},
    {2'd1, 2'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 3'b111},
    {2'd1, 2'd2, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 3'b001},
    {2'd1, 2'd3, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'b000},
    {2'd2, 2'd3, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 3'b010},
    {2'd3, 2'd2, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 3'b001},
    {2'd0, 2'd0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 3'b011}
  };
  string req_of [NV];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = 1'b0; obs_pulse = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic preload(input int n);
    for (int k = 0; k < n; k++) begin
      req_vc = 2'd2; req_ro = 1'b1; req_snoop = 1'b0; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic pulse_obs();
    obs_pulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    obs_pulse = 1'b0;
  endtask

  task automatic set_vc1_serial();
    req_vc = 2'd1; cfg_vc1_mode = 2'b01; req_ro = 1'b1; req_snoop = 1'b0;
  endtask

  initial begin
    req_of = '{"R3", "R3", "R3", "R4", "R4", "R4", "R5", "R5", "R8",
               "R6", "R6", "R8", "R7", "R7", "R8", "R1", "R6"};
    for (int i = 0; i < NV; i++) begin
      do_reset();
      preload(int'(VEC[i][22:21]));
      req_vc = VEC[i][20:19]; cfg_vc1_mode = VEC[i][18:17];
      cfg_vc0_strict = VEC[i][16]; cfg_no_alloc = VEC[i][15];
      req_ro = VEC[i][14]; req_snoop = VEC[i][13]; req_full_line = VEC[i][12];
      req_tag = VEC[i][11:4];
      #1;
      chk(req_of[i], 8'(req_ready), 8'(VEC[i][3]));
      chk("R9", 8'(issue_cmd), 8'(VEC[i][2:0]));
    end

    // R10: open after reset
    do_reset();
    set_vc1_serial(); cfg_no_alloc = 1'b0;
    #1 chk("R10", 8'(req_ready), 8'd1);

    // R2: pulse at zero ignored, then one issue and one retire
    pulse_obs();
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk("R2", 8'(req_ready), 8'd0);
    pulse_obs();
    #1 chk("R2", 8'(req_ready), 8'd1);

    // R2: simultaneous accept and retire keeps the count
    preload(1);
    req_vc = 2'd2; req_ro = 1'b1; req_valid = 1'b1; obs_pulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; obs_pulse = 1'b0;
    set_vc1_serial();
    #1 chk("R2", 8'(req_ready), 8'd0);
    pulse_obs();
    #1 chk("R2", 8'(req_ready), 8'd1);

    // R1: saturation and release
    do_reset();
    preload(3);
    req_vc = 2'd2; req_ro = 1'b1; req_snoop = 1'b0;
    #1 chk("R1", 8'(req_ready), 8'd0);
    pulse_obs();
    #1 chk("R1", 8'(req_ready), 8'd1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule